// File: doc/BRIEF.md
# Round-Robin Poller with One-Hot State

This block arbitrates among N requesters in round-robin order. Each cycle it looks at the request vector and the grant it issued last time. It then returns a one-hot grant for the first requester that comes after the previous winner, counting in rising index order. When no requester sits above the previous winner, the search wraps and the lowest-indexed requester wins. The grant is combinational from the requests within the cycle. The same grant is captured on the clock edge and becomes the reference for the next poll.

The state is the previous grant itself, kept as N bits. A suffix AND over the inverted state bits gives a mask that passes only positions strictly above the last winner. If the masked requests are non-empty they go to one fixed lowest-index-first encoder. Otherwise the raw requests go to that encoder. There is no binary pointer, no decoder and no rotator.

A typical use is as the scheduler for a set of queues, where a cell or packet is forwarded every cycle that `any_grant` is high.

Top module: `rr_mask_poller`

## Requirements
- R1: After reset the stored grant is all zeros, so the first poll grants the lowest-indexed active request. For example, `req`=4'b1010 gives `grant`=4'b0010.
- R2: `grant` has at most one bit set, and it is all zeros exactly when `req` is all zeros.
- R3: `any_grant` is high exactly when at least one bit of `req` is set.
- R4: If the last stored grant is at index k and some request at an index above k is active, the grant goes to the lowest such index.
- R5: If no request above the last winner k is active, the grant goes to the lowest active index overall. This includes k itself when k is the only requester.
- R6: On a rising clock edge with `any_grant` high, the stored state takes the value of `grant`. A cycle with `req` all zeros leaves it unchanged, so the next grant depends only on the last real winner.
- R7: A requester that holds its request continuously is granted within N consecutive polls.
- R8: `grant` never has a bit set where `req` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the stored grant updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the stored grant |
| req | input | N | Request vector, bit i for requester i |
| grant | output | N | One-hot grant for this cycle, all zeros when nothing is requested |
| any_grant | output | 1 | High when a grant is issued this cycle |

## Verification
The hardest case to reach is one specific stored winner combined with one specific request pattern. The bench gets there by resetting, then driving a single request bit to plant the winner it wants, and only then applying the pattern under test. It sweeps every planted winner, including the empty post-reset state, against all request patterns of a 4-requester instance. Idle cycles are inserted after planting to show that they do not move the state. A long pseudo-random run with requesters held high for many cycles then exercises wrap-around and the bounded wait against an arithmetic model.

// File: rtl/rr_mask_poller.sv
module rr_mask_poller #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any_grant
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] last_q;
  logic [N-1:0] above;
  logic [N-1:0] mreq;
  logic [N-1:0] pick;

  // above[i] = ~last_q[i] & ~last_q[i+1] & ... & ~last_q[N-1]
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_mask
      if (i == N - 1) begin : g_top
        assign above[i] = ~last_q[i];
      end else begin : g_mid
        assign above[i] = ~last_q[i] & above[i+1];
      end
    end
  endgenerate

  assign mreq      = req & above;
  assign pick      = (|mreq) ? mreq : req;
  assign grant     = pick & (~pick + ONE);
  assign any_grant = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= '0;
    else if (any_grant) last_q <= grant;
  end

endmodule

// File: rtl/rr_mask_poller_chk.sv
module rr_mask_poller_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic         any_grant,
  input logic [N-1:0] last_q
);

  localparam int CW = $clog2(N + 1) + 1;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_iff_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) == (grant == '0));

  assert_any_matches_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant == (grant != '0));

  assert_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  assert_state_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant |=> last_q == $past(grant));

  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_grant |=> $stable(last_q));

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_wait
      logic [CW-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wait_q <= '0;
        else if (req[i] && !grant[i]) wait_q <= wait_q + 1'b1;
        else                         wait_q <= '0;
      end
      assert_fair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req[i] && !grant[i]) |-> (int'(wait_q) < N - 1));
    end
  endgenerate

endmodule

bind rr_mask_poller rr_mask_poller_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .any_grant(any_grant), .last_q(last_q)
);

// File: tb/rr_mask_poller_test.sv
module rr_mask_poller_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant;
  logic         any_grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int last_idx = -1;
  int waits [N];

  rr_mask_poller #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any_grant(any_grant)
  );

  always #5 clk = ~clk;

  function automatic logic [N-1:0] model(input logic [N-1:0] r, input int last);
    for (int k = last + 1; k < N; k++) if (r[k]) return N'(1) << k;
    for (int k = 0; k < N; k++) if (r[k]) return N'(1) << k;
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (req %b)", tag, act, exp, req);
    end
  endtask

  // drive at negedge, check the combinational grant, let the posedge update state
  task automatic poll(input logic [N-1:0] r, input string tag);
    logic [N-1:0] e;
    @(negedge clk);
    req = r;
    #1;
    e = model(r, last_idx);
    check(grant === e, tag, grant, e);
    check(any_grant === (r != '0), "R3 any_grant", {{(N-1){1'b0}}, any_grant},
          {{(N-1){1'b0}}, r != '0});
    check((grant & ~r) == '0, "R8 subset", grant, r);
    for (int k = 0; k < N; k++) begin
      if (r[k] && !e[k]) begin
        waits[k]++;
        check(waits[k] < N, "R7 wait bound", N'(waits[k]), N'(N - 1));
      end else begin
        waits[k] = 0;
      end
    end
    if (e != '0) for (int k = 0; k < N; k++) if (e[k]) last_idx = k;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req = '0;
    last_idx = -1;
    for (int k = 0; k < N; k++) waits[k] = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [N-1:0] hold;

    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    check(grant === '0, "R1 grant in reset", grant, '0);
    rst_n = 1'b1;
    poll(4'b1010, "R1 first poll lowest");
    poll(4'b1010, "R4 next above last");
    poll(4'b1010, "R5 wrap to lowest");
    poll(4'b0010, "R5 sole requester repeats");

    // R4/R5 exhaustive: every planted state against every request pattern
    for (int s = -1; s < N; s++) begin
      for (int p = 0; p < (1 << N); p++) begin
        do_reset();
        if (s >= 0) poll(N'(1) << s, "R6 plant state");
        poll('0, "R6 idle leaves state");
        poll(N'(p), (s < 0) ? "R1 post-reset sweep" : "R4 R5 sweep");
      end
    end

    // R6: several idle cycles do not move the state
    do_reset();
    poll(4'b0100, "R6 plant");
    repeat (3) poll('0, "R2 idle gives zero grant");
    poll(4'b1111, "R6 continue after idle");

    // R7: random with persistent requesters
    do_reset();
    lfsr = 16'hACE1;
    hold = '0;
    for (int c = 0; c < 2000; c++) begin
      if (c % 97 == 0) hold = lfsr[N+3:4];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      poll(lfsr[N-1:0] | hold, "R7 random model");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule